// File: doc/BRIEF.md
# Masked Status Word Reader

This block sits behind a small register port used by a debug host. It takes up to eight 32-bit status words as parallel inputs and lets the host collect any subset of them through a single read address. The host first stores a selection mask, one bit per word. It then reads the status-read address repeatedly. Each read returns the next selected word in ascending index order, and after the highest selected word it goes back to the lowest.

A capability register reports how many status words are implemented. A domain-include register is decoded but holds nothing, because every status source is synchronous to the block clock. The number of implemented words is a parameter. The capability value and the set of mask bits that can be written both follow from it.

Accesses are single-cycle requests. A read request returns its data one cycle later together with a one-cycle valid pulse. A write request returns nothing.

Top module: `statsel_reader`

## Requirements
- R1: After reset the selection mask has every implemented bit set (0xFF when eight words exist), the read pointer is at word 0, and `rvalid_o` and `rdata_o` are 0.
- R2: A write to the select register at offset 0x0 places the read pointer on the lowest selected index, so the next status read returns that word.
- R3: Each status read at offset 0x8 returns the word at the pointer and then moves the pointer to the next higher selected index. Reads and writes of any other register leave the pointer unchanged.
- R4: After the highest selected word has been read, the next status read returns the lowest selected word. When one word is selected, every read returns that word.
- R5: Mask bits at or above the implemented word count cannot be set. A write leaves them at 0, and the select register reads them back as 0.
- R6: The capability register at offset 0x4 reads the implemented word count minus one in bits 7:0 and zero above. Writes to it have no effect.
- R7: The domain-include register at offset 0xC always reads zero and ignores writes.
- R8: Bits 31:8 of the select register read as zero whatever was written.
- R9: While the mask is all zeros, status reads return 0 and the pointer does not move.
- R10: A read request (`req_i`=1, `we_i`=0) produces `rvalid_o`=1 with its data in the following cycle. A write request (`req_i`=1, `we_i`=1) produces no `rvalid_o`.
- R11: Reads of any address other than 0x0, 0x4, 0x8 or 0xC return zero, and writes to such addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read for the current request |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| stat_words_i | input | NUM_WORDS*DATA_W | Status words, word k in bits k*DATA_W upward |
| rdata_o | output | DATA_W | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | One-cycle pulse the cycle after a read request |

## Verification
The bench builds the block with six implemented words. This lets the reset mask, the writable-bit limit and the capability value differ from their eight-word forms. The read sequence is tried with the full reset mask, with two sparse bits (which separates stepping to the next selected word from plain incrementing), with a single bit (the wrap onto itself), and with an empty mask. It is also tried with a mask that includes unimplemented bits, which shows whether they are dropped. Status values are changed between reads so that a stale or wrong index is visible. Reads and writes of the other registers are placed between status reads, which shows whether anything but a status read moves the pointer.

// File: rtl/statsel_pkg.sv
package statsel_pkg;

   // Width of the select, capability and domain fields
   localparam int SEL_W = 8;

   // Register byte offsets
   localparam int OFS_SEL  = 'h0;
   localparam int OFS_CAP  = 'h4;
   localparam int OFS_STAT = 'h8;
   localparam int OFS_DOM  = 'hC;

   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_SEL,
      ACC_CAP,
      ACC_STAT,
      ACC_DOM
   } acc_e;

   function automatic int idx_width(int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/statsel_mask.sv
module statsel_mask #(
   parameter int N = 8
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         wr_i,
   input  logic [N-1:0] wval_i,
   output logic [N-1:0] mask_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_o <= '1;
      else if (wr_i) mask_o <= wval_i;
   end

   // R5: after any write the stored mask equals the implemented part of the write
   AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> mask_o == $past(wval_i)); // R5

endmodule

// File: rtl/statsel_pick.sv
module statsel_pick
   import statsel_pkg::*;
#(
   parameter int N     = 8,
   localparam int IDXW = idx_width(N)
) (
   input  logic [N-1:0]  mask_i,
   input  logic [IDXW:0] from_i,
   output logic [IDXW-1:0] idx_o,
   output logic          hit_o
);

   logic [IDXW-1:0] lo_idx, up_idx;
   logic            lo_any, up_any;

   // Scan downward so the last match kept is the lowest index
   always_comb begin
      lo_idx = '0;
      up_idx = '0;
      lo_any = 1'b0;
      up_any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask_i[i]) begin
            lo_idx = IDXW'(i);
            lo_any = 1'b1;
            if ((IDXW + 1)'(i) >= from_i) begin
               up_idx = IDXW'(i);
               up_any = 1'b1;
            end
         end
      end
   end

   assign idx_o = up_any ? up_idx : lo_idx;
   assign hit_o = lo_any;

endmodule

// File: rtl/statsel_ptr.sv
module statsel_ptr #(
   parameter int IDXW = 3
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            load_i,
   input  logic [IDXW-1:0] load_idx_i,
   input  logic            adv_i,
   input  logic [IDXW-1:0] adv_idx_i,
   output logic [IDXW-1:0] ptr_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_o <= '0;
      else if (load_i) ptr_o <= load_idx_i;
      else if (adv_i)  ptr_o <= adv_idx_i;
   end

   AST_PTR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !adv_i) |=> $stable(ptr_o)); // R3

endmodule

// File: rtl/statsel_reader.sv
module statsel_reader
   import statsel_pkg::*;
#(
   parameter int NUM_WORDS = 8,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        req_i,
   input  logic                        we_i,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   input  logic [NUM_WORDS*DATA_W-1:0] stat_words_i,
   output logic [DATA_W-1:0]           rdata_o,
   output logic                        rvalid_o
);

   localparam int IDXW    = idx_width(NUM_WORDS);
   localparam int CAP_VAL = NUM_WORDS - 1;

   // Elaboration checks
   if (NUM_WORDS < 1 || NUM_WORDS > SEL_W) begin : g_bad_words
      $error("statsel_reader: NUM_WORDS must be 1..%0d", SEL_W);
   end
   if (DATA_W < SEL_W + 1) begin : g_bad_data
      $error("statsel_reader: DATA_W too small");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("statsel_reader: ADDR_W must be at least 4");
   end

   // Address decode
   acc_e acc;
   always_comb begin
      acc = ACC_NONE;
      if (addr_i == ADDR_W'(OFS_SEL))       acc = ACC_SEL;
      else if (addr_i == ADDR_W'(OFS_CAP))  acc = ACC_CAP;
      else if (addr_i == ADDR_W'(OFS_STAT)) acc = ACC_STAT;
      else if (addr_i == ADDR_W'(OFS_DOM))  acc = ACC_DOM;
   end

   logic rd_req, sel_wr, stat_rd;
   assign rd_req  = req_i && !we_i;
   assign sel_wr  = req_i && we_i && (acc == ACC_SEL);
   assign stat_rd = rd_req && (acc == ACC_STAT);

   // Only implemented bits of the write data reach the mask
   logic [NUM_WORDS-1:0] sel_wval;
   logic                 unused_wbits;
   assign sel_wval     = wdata_i[NUM_WORDS-1:0];
   assign unused_wbits = ^wdata_i[DATA_W-1:NUM_WORDS];

   logic [NUM_WORDS-1:0] mask;
   statsel_mask #(.N(NUM_WORDS)) u_mask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (sel_wr),
      .wval_i (sel_wval),
      .mask_o (mask)
   );

   logic [IDXW-1:0] ptr;
   logic [IDXW-1:0] first_idx, next_idx;
   logic            first_hit, mask_hit;

   // Lowest bit of the incoming mask value
   statsel_pick #(.N(NUM_WORDS)) u_pick_first (
      .mask_i (sel_wval),
      .from_i ('0),
      .idx_o  (first_idx),
      .hit_o  (first_hit)
   );

   // Next selected bit above the pointer, wrapping to the lowest
   statsel_pick #(.N(NUM_WORDS)) u_pick_next (
      .mask_i (mask),
      .from_i ({1'b0, ptr} + (IDXW + 1)'(1)),
      .idx_o  (next_idx),
      .hit_o  (mask_hit)
   );

   logic unused_first_hit;
   assign unused_first_hit = first_hit;

   statsel_ptr #(.IDXW(IDXW)) u_ptr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (sel_wr),
      .load_idx_i (first_idx),
      .adv_i      (stat_rd && mask_hit),
      .adv_idx_i  (next_idx),
      .ptr_o      (ptr)
   );

   // Word at the pointer
   logic [DATA_W-1:0] cur_word;
   always_comb begin
      cur_word = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         if (ptr == IDXW'(i)) cur_word = stat_words_i[i*DATA_W +: DATA_W];
      end
   end

   // Read mux
   logic [DATA_W-1:0] rd_val;
   always_comb begin
      unique case (acc)
         ACC_SEL:  rd_val = DATA_W'(mask);
         ACC_CAP:  rd_val = DATA_W'(CAP_VAL);
         ACC_STAT: rd_val = mask_hit ? cur_word : '0;
         default:  rd_val = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= rd_req;
         if (rd_req) rdata_o <= rd_val;
      end
   end

   // Checks
   AST_PTR_ON_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|mask) |-> mask[ptr]); // R2

   AST_STEP_AWAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd && $countones(mask) > 1) |=> ptr != $past(ptr)); // R3

   AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_rd && mask == '0) |=> ($stable(ptr) && rdata_o == '0)); // R9

   AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && acc == ACC_CAP) |=> rdata_o == DATA_W'(CAP_VAL)); // R6

   AST_DOM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && acc == ACC_DOM) |=> rdata_o == '0); // R7

   AST_SEL_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && acc == ACC_SEL) |=> rdata_o[DATA_W-1:SEL_W] == '0); // R8

   AST_READ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_req |=> rvalid_o); // R10

   AST_WRITE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i && we_i) |=> !rvalid_o); // R10

   AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_req && acc == ACC_NONE) |=> rdata_o == '0); // R11

endmodule

// File: tb/statsel_reader_test.sv
module statsel_reader_test;

   localparam int NW = 6;
   localparam int DW = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req = 1'b0;
   logic              we = 1'b0;
   logic [3:0]        addr = '0;
   logic [DW-1:0]     wdata = '0;
   logic [NW*DW-1:0]  words = '0;
   logic [DW-1:0]     rdata;
   logic              rvalid;

   always #2 clk = ~clk;

   statsel_reader #(.NUM_WORDS(NW), .DATA_W(DW), .ADDR_W(4)) uut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_i        (req),
      .we_i         (we),
      .addr_i       (addr),
      .wdata_i      (wdata),
      .stat_words_i (words),
      .rdata_o      (rdata),
      .rvalid_o     (rvalid)
   );

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [DW-1:0] val;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int   gen = 0;

   function automatic logic [DW-1:0] wv(int i, int g);
      return 32'h5A00_0000 ^ (DW'(g) << 16) ^ (DW'(i) * 32'h0000_1111);
   endfunction

   task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_words(int g);
      gen = g;
      for (int i = 0; i < NW; i++) words[i*DW +: DW] = wv(i, g);
   endtask

   task automatic rd(logic [3:0] a, logic [DW-1:0] exp, string tag);
      exp_t e;
      @(negedge clk);
      e.val = exp;
      e.tag = tag;
      sb.push_back(e);
      req  = 1'b1;
      we   = 1'b0;
      addr = a;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wr(logic [3:0] a, logic [DW-1:0] d);
      @(negedge clk);
      req   = 1'b1;
      we    = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      req = 1'b0;
      we  = 1'b0;
      check(rvalid == 1'b0, "R10 write gives no rvalid", {31'b0, rvalid}, '0);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rvalid) begin
         if (sb.size() == 0) begin
            check(1'b0, "R10 unexpected rvalid", rdata, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(rdata === e.val, e.tag, rdata, e.val);
         end
      end
   end

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (sb.size() != 0) check(1'b0, "R10 missing responses", DW'(sb.size()), '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      check(1'b0, "watchdog expired", '0, '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      set_words(0);
      repeat (3) @(negedge clk);
      check(rvalid == 1'b0, "R1 rvalid in reset", {31'b0, rvalid}, '0);
      check(rdata == '0, "R1 rdata in reset", rdata, '0);
      rst_n = 1'b1;

      // R1: reset mask and pointer; R3/R4 full walk and wrap
      rd(4'h0, 32'h0000_003F, "R1 reset mask");
      for (int i = 0; i < NW; i++) rd(4'h8, wv(i, 0), "R1 R3 full-mask walk");
      rd(4'h8, wv(0, 0), "R4 wrap to lowest");

      // R2/R3: sparse mask, other register reads do not advance
      set_words(1);
      wr(4'h0, 32'h0000_0014);
      rd(4'h8, wv(2, 1), "R2 lowest after select write");
      rd(4'h0, 32'h0000_0014, "R3 select read between status reads");
      rd(4'h8, wv(4, 1), "R3 next selected word");
      rd(4'h8, wv(2, 1), "R4 sparse wrap");

      // R5/R8: unimplemented and upper bits dropped
      wr(4'h0, 32'hFFFF_FFC1);
      rd(4'h0, 32'h0000_0001, "R5 R8 masked select value");
      rd(4'h8, wv(0, 1), "R4 single selected");
      rd(4'h8, wv(0, 1), "R4 single selected repeats");

      // R9: empty mask
      wr(4'h0, 32'h0000_00C0);
      rd(4'h0, 32'h0000_0000, "R5 only unimplemented bits");
      rd(4'h8, 32'h0, "R9 empty mask reads zero");
      rd(4'h8, 32'h0, "R9 empty mask reads zero again");
      wr(4'h0, 32'h0000_0020);
      rd(4'h8, wv(5, 1), "R2 top word selected");
      rd(4'h8, wv(5, 1), "R4 top word repeats");

      // R3: live status values
      wr(4'h0, 32'h0000_000A);
      rd(4'h8, wv(1, 1), "R2 lowest of 0x0A");
      set_words(2);
      rd(4'h8, wv(3, 2), "R3 live updated word");
      rd(4'h8, wv(1, 2), "R4 wrap with new values");

      // R6: capability
      rd(4'h4, 32'h0000_0005, "R6 capability value");
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, 32'h0000_0005, "R6 capability after write");
      rd(4'h8, wv(3, 2), "R3 pointer kept over other accesses");

      // R7: domain register
      wr(4'hC, 32'hFFFF_FFFF);
      rd(4'hC, 32'h0, "R7 domain reads zero");

      // R11: unmapped addresses
      wr(4'h2, 32'hFFFF_FFFF);
      rd(4'h2, 32'h0, "R11 unmapped read");
      rd(4'hD, 32'h0, "R11 unmapped read high");
      rd(4'h8, wv(1, 2), "R11 unmapped write left pointer");

      // R5: full write clipped to implemented bits
      wr(4'h0, 32'h0000_00FF);
      rd(4'h0, 32'h0000_003F, "R5 all-ones select clipped");
      rd(4'h8, wv(0, 2), "R2 lowest after full select");

      finish_run();
   end

endmodule